// File: doc/BRIEF.md
# Linked Up-Counter Pair with Trigger Chaining

Two up-counting timers run from one shared clock. The first, the lead timer, has a prescaler, a period register that sets its wrap point and a compare register that shapes a reference waveform. A selector picks which of the lead timer's internal signals goes out as its trigger output: its enable, its wrap pulse or its compare reference. The second, the follower timer, picks its trigger input with a select field. It passes that input through a two-flop resynchroniser. A mode controller then uses it either as a level gate on counting or as a start event that turns on the follower's enable in hardware.

Software drives both timers through a narrow write port. Each write sets an enable, fires a reset strobe, loads a counter, or sets a period, a prescaler, a mode field or the follower's event flag. The counters, the lead wrap pulse, the reference, the trigger output, the follower enable and the event flag are all visible on output ports.

Top module: `tmr_pair`

## Requirements
- R1: When the lead timer is enabled, its counter advances once every (prescaler+1) clocks. When it advances from a count equal to its period register it goes to 0. In the cycle after that edge, `mstrUpdate` is high for exactly one clock, unless a reset strobe or counter load took that edge.
- R2: Register map and reset/load behaviour. Writes use `wrAddr` and `wrData`:
  - 0: lead control, bit0 enable, bits[3:1] trigger-output select.
  - 1: lead reset strobe, bit0.
  - 2: lead counter load.
  - 3: lead period.
  - 4: lead prescaler.
  - 5: lead compare.
  - 6: follower control, bit0 enable, bits[3:1] mode, bits[8:4] trigger select.
  - 7: follower reset strobe, bit0.
  - 8: follower counter load.
  - 9: follower period.
  - 10: follower prescaler.
  - 11: follower flag, bit0 written into the flag.

  A reset strobe clears that timer's counter and prescaler. A load writes the counter and leaves the prescaler alone. On a shared edge the strobe wins over the load, and the load wins over a count step.
- R3: `oc1Ref` is high exactly while the lead count is below the lead compare register.
- R4: `trgo` follows the trigger-output select: 3'b001 gives the lead enable, 3'b010 gives the lead wrap pulse, 3'b100 gives `oc1Ref`, and any other code gives 0.
- R5: Trigger select 5'b00010 routes `trgo` to the follower's trigger input. Any other select value holds that input low.
- R6: The follower acts on a change of its trigger input at the third clock edge after the edge that changed it: two resynchronising flops, then one edge for the action.
- R7: In gated mode (3'b101), the follower advances on its prescaled tick only while its enable is set and its resynchronised trigger is high. When the trigger is low the count holds and is not cleared.
- R8: In trigger mode (3'b110), a rising resynchronised trigger sets the follower enable. The follower then counts on from whatever value it held, and keeps counting until software clears the enable.
- R9: The follower flag is set by both trigger edges in gated mode and by the rising edge in trigger mode. Otherwise it takes bit0 of a flag write. A hardware set wins over a software clear on the same edge.
- R10: After reset:
  - both counters are 0 and both prescalers are 0;
  - both periods are all ones;
  - enables, modes, selects, the compare register and the flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared kernel clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register index |
| wrData | input | TMR_W | Write data |
| mstrCount | output | TMR_W | Lead timer counter |
| slvCount | output | TMR_W | Follower timer counter |
| mstrUpdate | output | 1 | One-clock lead wrap pulse |
| oc1Ref | output | 1 | Lead compare reference |
| trgo | output | 1 | Lead trigger output |
| slvEnable | output | 1 | Follower enable bit |
| slvTrigFlag | output | 1 | Follower trigger-event flag |

## Verification
The follower flag can receive a hardware set from a resynchronised gate edge and a software clear on the same clock edge. The bench times a flag-clear write so that it lands on the exact edge where the gate's rising edge takes effect, three edges after the compare write that raised the reference. It then requires the flag to read 1. The same two-clock resynchroniser timing is used to land a trigger-mode start, and the bench checks that the enable is still 0 one edge before it becomes 1.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int TMR_W  = 16;
  parameter int ADDR_W = 4;
  parameter int SEL_W  = 3;
  parameter int TSEL_W = 5;

  localparam logic [ADDR_W-1:0] A_M_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_M_EVT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_M_CNT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_M_PER  = 4'd3;
  localparam logic [ADDR_W-1:0] A_M_PSC  = 4'd4;
  localparam logic [ADDR_W-1:0] A_M_CMP  = 4'd5;
  localparam logic [ADDR_W-1:0] A_S_CTRL = 4'd6;
  localparam logic [ADDR_W-1:0] A_S_EVT  = 4'd7;
  localparam logic [ADDR_W-1:0] A_S_CNT  = 4'd8;
  localparam logic [ADDR_W-1:0] A_S_PER  = 4'd9;
  localparam logic [ADDR_W-1:0] A_S_PSC  = 4'd10;
  localparam logic [ADDR_W-1:0] A_S_FLAG = 4'd11;

  localparam logic [SEL_W-1:0] OUT_ENABLE = 3'b001;
  localparam logic [SEL_W-1:0] OUT_WRAP   = 3'b010;
  localparam logic [SEL_W-1:0] OUT_REF    = 3'b100;

  localparam logic [SEL_W-1:0] MODE_GATED = 3'b101;
  localparam logic [SEL_W-1:0] MODE_START = 3'b110;

  localparam logic [TSEL_W-1:0] TSEL_LEAD = 5'b00010;

  typedef struct packed {
    logic             mUg;
    logic             mLd;
    logic             sUg;
    logic             sLd;
    logic [TMR_W-1:0] ldVal;
  } strobe_t;

  typedef struct packed {
    logic              mEn;
    logic [SEL_W-1:0]  mOutSel;
    logic [TMR_W-1:0]  mPsc;
    logic [TMR_W-1:0]  mPer;
    logic [TMR_W-1:0]  mCmp;
    logic              sEn;
    logic [SEL_W-1:0]  sMode;
    logic [TSEL_W-1:0] sTrigSel;
    logic [TMR_W-1:0]  sPsc;
    logic [TMR_W-1:0]  sPer;
  } cfg_t;

  typedef struct packed {
    logic trigRise;
    logic trigFall;
  } evt_t;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic         ug,
  input  logic         ld,
  input  logic [W-1:0] ldVal,
  input  logic [W-1:0] pscVal,
  input  logic [W-1:0] perVal,
  output logic [W-1:0] cnt,
  output logic         wrapNow
);
  logic [W-1:0] psc;
  logic         tick;

  assign tick    = run && (psc == pscVal);
  assign wrapNow = tick && (cnt == perVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psc <= '0;
      cnt <= '0;
    end else begin
      if (ug)       psc <= '0;
      else if (run) psc <= (psc == pscVal) ? '0 : psc + 1'b1;

      if (ug)        cnt <= '0;
      else if (ld)   cnt <= ldVal;
      else if (tick) cnt <= (cnt == perVal) ? '0 : cnt + 1'b1;
    end
  end

  // R1: a wrap step lands on zero
  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    wrapNow && !ug && !ld |=> cnt == '0);
  // R2: reset strobe clears counter and prescaler
  p_ug_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    ug |=> (cnt == '0) && (psc == '0));
  // R2: a load without strobe takes the written value
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    ld && !ug |=> cnt == $past(ldVal));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [TMR_W-1:0]  wrData,
  input  evt_t              evt,
  output strobe_t           stb,
  output cfg_t              cfg,
  output logic              trigFlag
);
  logic              mEn, sEn;
  logic [SEL_W-1:0]  mOutSel, sMode;
  logic [TSEL_W-1:0] sTrigSel;
  logic [TMR_W-1:0]  mPsc, mPer, mCmp, sPsc, sPer;
  logic              gatedMode, startMode, flagSet;

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return wrEn && (wrAddr == a);
  endfunction

  always_comb begin
    stb.mUg   = hit(A_M_EVT) && wrData[0];
    stb.mLd   = hit(A_M_CNT);
    stb.sUg   = hit(A_S_EVT) && wrData[0];
    stb.sLd   = hit(A_S_CNT);
    stb.ldVal = wrData;
  end

  assign gatedMode = (sMode == MODE_GATED);
  assign startMode = (sMode == MODE_START);
  assign flagSet   = (gatedMode && (evt.trigRise || evt.trigFall)) ||
                     (startMode && evt.trigRise);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mEn      <= 1'b0;
      mOutSel  <= '0;
      mPsc     <= '0;
      mPer     <= '1;
      mCmp     <= '0;
      sMode    <= '0;
      sTrigSel <= '0;
      sPsc     <= '0;
      sPer     <= '1;
    end else begin
      if (hit(A_M_CTRL)) begin
        mEn     <= wrData[0];
        mOutSel <= wrData[3:1];
      end
      if (hit(A_M_PSC)) mPsc <= wrData;
      if (hit(A_M_PER)) mPer <= wrData;
      if (hit(A_M_CMP)) mCmp <= wrData;
      if (hit(A_S_CTRL)) begin
        sMode    <= wrData[3:1];
        sTrigSel <= wrData[8:4];
      end
      if (hit(A_S_PSC)) sPsc <= wrData;
      if (hit(A_S_PER)) sPer <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sEn      <= 1'b0;
      trigFlag <= 1'b0;
    end else begin
      if (startMode && evt.trigRise) sEn <= 1'b1;
      else if (hit(A_S_CTRL))        sEn <= wrData[0];

      if (flagSet)             trigFlag <= 1'b1;
      else if (hit(A_S_FLAG))  trigFlag <= wrData[0];
    end
  end

  always_comb begin
    cfg.mEn      = mEn;
    cfg.mOutSel  = mOutSel;
    cfg.mPsc     = mPsc;
    cfg.mPer     = mPer;
    cfg.mCmp     = mCmp;
    cfg.sEn      = sEn;
    cfg.sMode    = sMode;
    cfg.sTrigSel = sTrigSel;
    cfg.sPsc     = sPsc;
    cfg.sPer     = sPer;
  end

  // R8: a start edge in trigger mode turns the follower on
  p_start_sets_en_r8: assert property (@(posedge clk) disable iff (!rstN)
    startMode && evt.trigRise |=> sEn);
  // R9: hardware set beats any software write
  p_flag_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    flagSet |=> trigFlag);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfg,
  input  strobe_t          stb,
  output logic [TMR_W-1:0] mCnt,
  output logic [TMR_W-1:0] sCnt,
  output logic             mUpd,
  output logic             refOut,
  output logic             trigOut,
  output evt_t             evt
);
  logic              mWrapNow, sWrapNow, trigIn, syncLvl, syncPrev, sRun;
  logic [SYNC_N:0]   syncPipe;

  tmr_counter #(.W(TMR_W)) u_lead (
    .clk(clk), .rstN(rstN), .run(cfg.mEn), .ug(stb.mUg), .ld(stb.mLd),
    .ldVal(stb.ldVal), .pscVal(cfg.mPsc), .perVal(cfg.mPer),
    .cnt(mCnt), .wrapNow(mWrapNow));

  always_ff @(posedge clk) begin
    if (!rstN) mUpd <= 1'b0;
    else       mUpd <= mWrapNow && !stb.mUg && !stb.mLd;
  end

  assign refOut = (mCnt < cfg.mCmp);

  always_comb begin
    unique case (cfg.mOutSel)
      OUT_ENABLE: trigOut = cfg.mEn;
      OUT_WRAP:   trigOut = mUpd;
      OUT_REF:    trigOut = refOut;
      default:    trigOut = 1'b0;
    endcase
  end

  assign trigIn = (cfg.sTrigSel == TSEL_LEAD) ? trigOut : 1'b0;

  always_ff @(posedge clk) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_N-1:0], trigIn};
  end

  assign syncLvl      = syncPipe[SYNC_N-1];
  assign syncPrev     = syncPipe[SYNC_N];
  assign evt.trigRise = syncLvl && !syncPrev;
  assign evt.trigFall = !syncLvl && syncPrev;

  generate
    if (SYNC_N < 1) begin : g_bad_sync
      initial $error("SYNC_N must be at least 1");
    end
  endgenerate

  assign sRun = cfg.sEn && ((cfg.sMode != MODE_GATED) || syncLvl);

  tmr_counter #(.W(TMR_W)) u_follow (
    .clk(clk), .rstN(rstN), .run(sRun), .ug(stb.sUg), .ld(stb.sLd),
    .ldVal(stb.ldVal), .pscVal(cfg.sPsc), .perVal(cfg.sPer),
    .cnt(sCnt), .wrapNow(sWrapNow));

  // R7: a closed gate freezes the follower count
  p_gate_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.sMode == MODE_GATED) && !syncLvl && !stb.sUg && !stb.sLd
      |=> $stable(sCnt));
  // R1: the wrap pulse lasts a single clock
  p_upd_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    mUpd && (cfg.mPsc != '0) |=> !mUpd);
  // R1: follower wrap also returns to zero
  p_follow_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    sWrapNow && !stb.sUg && !stb.sLd |=> sCnt == '0);
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [TMR_W-1:0]  wrData,
  output logic [TMR_W-1:0]  mstrCount,
  output logic [TMR_W-1:0]  slvCount,
  output logic              mstrUpdate,
  output logic              oc1Ref,
  output logic              trgo,
  output logic              slvEnable,
  output logic              slvTrigFlag
);
  strobe_t stb;
  cfg_t    cfg;
  evt_t    evt;

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evt(evt), .stb(stb), .cfg(cfg), .trigFlag(slvTrigFlag));

  tmr_datapath #(.SYNC_N(2)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb),
    .mCnt(mstrCount), .sCnt(slvCount), .mUpd(mstrUpdate),
    .refOut(oc1Ref), .trigOut(trgo), .evt(evt));

  assign slvEnable = cfg.sEn;
endmodule

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] mstrCount, slvCount;
  logic        mstrUpdate, oc1Ref, trgo, slvEnable, slvTrigFlag;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  tmr_pair u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .mstrCount(mstrCount), .slvCount(slvCount), .mstrUpdate(mstrUpdate),
    .oc1Ref(oc1Ref), .trgo(trgo), .slvEnable(slvEnable),
    .slvTrigFlag(slvTrigFlag));

  // behavioural reference state
  logic [15:0] mCnt, mPsc, sCnt, sPsc, rMPsc, rMPer, rMCmp, rSPsc, rSPer;
  logic [2:0]  rMSel, rSMode;
  logic [4:0]  rTSel;
  logic        rMEn, rSEn, flag, mUpd;
  logic        sy1, sy2, sy3;

  function automatic logic modelTrgo();
    case (rMSel)
      3'b001:  return rMEn;
      3'b010:  return mUpd;
      3'b100:  return mCnt < rMCmp;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPsc = 0; sCnt = 0; sPsc = 0;
      rMPsc = 0; rMPer = 16'hFFFF; rMCmp = 0; rSPsc = 0; rSPer = 16'hFFFF;
      rMSel = 0; rSMode = 0; rTSel = 0; rMEn = 0; rSEn = 0; flag = 0;
      mUpd = 0; sy1 = 0; sy2 = 0; sy3 = 0;
    end else begin
      logic tIn, rise, fall, mTick, sTick, sRun, mUg, mLd, sUg, sLd, nUpd;
      logic [15:0] nM, nS;
      tIn  = (rTSel == 5'd2) ? modelTrgo() : 1'b0;
      rise = sy2 && !sy3;
      fall = !sy2 && sy3;
      mUg = wrEn && wrAddr == 4'd1 && wrData[0];
      mLd = wrEn && wrAddr == 4'd2;
      sUg = wrEn && wrAddr == 4'd7 && wrData[0];
      sLd = wrEn && wrAddr == 4'd8;
      mTick = rMEn && mPsc == rMPsc;
      nUpd  = mTick && mCnt == rMPer && !mUg && !mLd;
      nM = mUg ? 16'd0 : mLd ? wrData : mTick ? ((mCnt == rMPer) ? 16'd0 : mCnt + 16'd1) : mCnt;
      if (mUg) mPsc = 0; else if (rMEn) mPsc = (mPsc == rMPsc) ? 16'd0 : mPsc + 16'd1;
      sRun  = rSEn && (rSMode != 3'd5 || sy2);
      sTick = sRun && sPsc == rSPsc;
      nS = sUg ? 16'd0 : sLd ? wrData : sTick ? ((sCnt == rSPer) ? 16'd0 : sCnt + 16'd1) : sCnt;
      if (sUg) sPsc = 0; else if (sRun) sPsc = (sPsc == rSPsc) ? 16'd0 : sPsc + 16'd1;
      if ((rSMode == 3'd5 && (rise || fall)) || (rSMode == 3'd6 && rise)) flag = 1;
      else if (wrEn && wrAddr == 4'd11) flag = wrData[0];
      if (rSMode == 3'd6 && rise) rSEn = 1;
      else if (wrEn && wrAddr == 4'd6) rSEn = wrData[0];
      mCnt = nM; sCnt = nS; mUpd = nUpd;
      sy3 = sy2; sy2 = sy1; sy1 = tIn;
      if (wrEn) begin
        case (wrAddr)
          4'd0:  begin rMEn = wrData[0]; rMSel = wrData[3:1]; end
          4'd3:  rMPer = wrData;
          4'd4:  rMPsc = wrData;
          4'd5:  rMCmp = wrData;
          4'd6:  begin rSMode = wrData[3:1]; rTSel = wrData[8:4]; end
          4'd9:  rSPer = wrData;
          4'd10: rSPsc = wrData;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN) begin
      check("R1", "mstrCount", mstrCount, mCnt);
      check("R1", "mstrUpdate", mstrUpdate, mUpd);
      check("R3", "oc1Ref", oc1Ref, mCnt < rMCmp);
      check("R4", "trgo", trgo, modelTrgo());
      check("R7", "slvCount", slvCount, sCnt);
      check("R8", "slvEnable", slvEnable, rSEn);
      check("R9", "slvTrigFlag", slvTrigFlag, flag);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        idle(5);
        @(negedge clk); rstN = 1'b1;
        @(posedge clk); @(negedge clk);
        // R10: reset state
        check("R10", "mstrCount", mstrCount, 0);
        check("R10", "slvCount", slvCount, 0);
        check("R10", "flag", slvTrigFlag, 0);
        check("R10", "enable", slvEnable, 0);

        // scenario 1: follower gated by the lead reference
        wr(4'd4, 16'd2); wr(4'd10, 16'd2);
        wr(4'd5, 16'd0);
        wr(4'd1, 16'd1); wr(4'd7, 16'd1);        // R2 reset strobes
        check("R2", "lead cleared", mstrCount, 0);
        wr(4'd8, 16'h00E7);                     // R2 load
        check("R2", "follower loaded", slvCount, 16'hE7);
        wr(4'd6, 16'h002B);                     // enable, gated, select lead
        wr(4'd0, 16'h0008);                     // output ref, lead stopped
        check("R4", "trgo low with ref low", trgo, 0);
        wr(4'd5, 16'd1);                        // edge E: reference rises
        check("R3", "ref high", oc1Ref, 1);
        idle(2);                                // after E+2
        check("R6", "flag not yet set", slvTrigFlag, 0);
        wr(4'd11, 16'd0);                       // clear lands on E+3
        check("R9", "set wins over clear", slvTrigFlag, 1);
        idle(3);
        wr(4'd5, 16'd0);                        // E+7: reference falls
        idle(20);
        check("R7", "gated count stops at E9", slvCount, 16'hE9);
        check("R9", "falling gate sets flag", slvTrigFlag, 1);
        wr(4'd11, 16'd0);
        check("R9", "software clear", slvTrigFlag, 0);

        // free-running lead with reference gating
        wr(4'd3, 16'd5); wr(4'd5, 16'd3);
        wr(4'd0, 16'h0009);
        idle(100);
        wr(4'd0, 16'h0008);

        // scenario 2: follower started by the lead wrap pulse
        wr(4'd6, 16'h003C);                     // trigger mode, wrong select
        wr(4'd11, 16'd0);
        wr(4'd7, 16'd1);
        wr(4'd8, 16'h00AB);
        wr(4'd0, 16'h0005);                     // lead runs, output wrap
        idle(40);
        check("R5", "other select ignored", slvEnable, 0);
        check("R5", "count untouched", slvCount, 16'hAB);
        wr(4'd6, 16'h002C);                     // select lead
        while (mstrUpdate !== 1'b1) @(negedge clk); // after edge U
        idle(2);
        check("R6", "enable still low at U+2", slvEnable, 0);
        idle(1);
        check("R8", "enable set at U+3", slvEnable, 1);
        check("R9", "start edge sets flag", slvTrigFlag, 1);
        idle(3);
        check("R8", "counts on from held value", slvCount, 16'hAC);
        idle(60);
        wr(4'd6, 16'h002C & 16'hFFFE);
        idle(10);
      end
      begin
        while (cycles < 100000) begin
          @(posedge clk);
          cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule